// File: doc/BRIEF.md
# Self-Synchronising PRBS Bit Error Checker

This block sits on the receive side of a serial link under test. It takes one data bit per enabled clock and checks it against a pseudo-random binary sequence that it generates locally. The local sequence is not preloaded. The checker first copies the incoming bits into its reference shift register. It then closes the register's own feedback loop, so the reference runs freely and predicts each later bit. Every enabled bit is compared with that prediction.

Lock is judged over windows of compared bits, with separate settings for gaining lock and for losing it. This gives hysteresis, so a marginal link does not toggle between states. If too many mismatches arrive while lock is still being confirmed, the checker starts over and re-seeds the register from the stream.

Once locked, the checker reports the number of compared bits and the number of errors. Both counters saturate instead of wrapping. A 32-bit block mask and a one-in-32 bit mask can take chosen positions out of both counters, so the ratio of the two counters stays a true error rate for the positions that remain.

Top module: `prbs_chk`

## Requirements
- R1: After a synchronous reset, `in_sync` is 0 and `err_cnt` and `bit_cnt` are 0.
- R2: `poly_sel` picks the recurrence b[t] = b[t-n] XOR b[t-m]. The encodings are 0:(7,6), 1:(9,5), 2:(11,9), 3:(15,14), 4:(20,3), 5:(23,18), and 6 or 7:(31,28). In acquisition, exactly n enabled bits are loaded into the reference. After that, every enabled bit is compared with the value the recurrence predicts from the reference, and the reference advances on its own prediction.
- R3: Lock is confirmed when one check window of 10^(k+1) compared bits ends with at most 10 mismatches. The gain exponent k is `gain_sel`, clamped to 2..8. `in_sync` rises on the clock edge that takes the last bit of that window. For PRBS7 with k=2, this is the 1007th enabled bit after acquisition begins.
- R4: During confirmation, an 11th mismatch sends the checker back to acquisition. A stream that follows a different recurrence therefore never reaches lock.
- R5: While locked, loss windows of 10^(k+1) compared bits run back to back, starting at the lock edge. The loss exponent k is `loss_sel`, clamped to 2..8. A window with 10 mismatches keeps lock. The 11th mismatch in one window clears `in_sync` on the edge that takes that bit.
- R6: After lock is lost, the reference is re-seeded from the next n received bits. A clean stream regains lock n + 10^(k+1) enabled bits later.
- R7: Clock cycles with `rx_en` low change no state, whatever the value of `rx_bit`.
- R8: Both counters clear on the edge that declares lock. They count only bits taken while locked, and only bits at unmasked positions. `err_cnt` counts the mismatches among those bits.
- R9: A position counter restarts at 0 on the lock edge and advances once per locked bit. With `blk_mask_en` set, the positions whose upper bits (position >> 5) equal `blk_mask_idx` are masked. This is a run of 32 consecutive positions.
- R10: With `bit_mask_en` set, the positions whose low five bits equal `bit_mask_off` are masked. Both masks may be active together.
- R11: `bit_cnt` and `err_cnt` stop at their all-ones value instead of wrapping.
- R12: The gain window and the loss window are set independently. Gain k=3 with loss k=2 confirms lock over 10000 bits and judges loss over 1000-bit windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_bit | input | 1 | Received data bit |
| rx_en | input | 1 | `rx_bit` is valid this cycle |
| poly_sel | input | 3 | Sequence select (encodings in R2) |
| gain_sel | input | 4 | Gain window exponent k, clamped to 2..8 |
| loss_sel | input | 4 | Loss window exponent k, clamped to 2..8 |
| blk_mask_en | input | 1 | Enable the 32-position block mask |
| blk_mask_idx | input | POS_W-5 | Index of the masked block (position >> 5) |
| bit_mask_en | input | 1 | Enable the one-in-32 mask |
| bit_mask_off | input | 5 | Masked offset within every 32 positions |
| in_sync | output | 1 | Lock status |
| err_cnt | output | CNT_W | Saturating count of mismatches at unmasked positions |
| bit_cnt | output | CNT_W | Saturating count of unmasked compared bits |

## Verification
The assertions check the counter rules on every cycle. The counters stay frozen while unlocked and on idle cycles. They step by at most one, never pass their all-ones value once they reach it, and keep the error count at or below the bit count. Lock only ever rises on an enabled bit. The exact cycle of lock gain and lock loss, the hysteresis between 10 and 11 errors, re-seeding, the polynomial select and the mask positions can only be shown by the bench's scenarios. In those scenarios a reference sequence is generated inside the bench and chosen bits are flipped.

// File: rtl/prbs_chk_pkg.sv
// Shared constants, state type and lookup functions for the PRBS checker.
// Assumes each window exponent is clamped to 2..8 and each window fits in 32 bits.
package prbs_chk_pkg;

    localparam int REF_W = 31;

    typedef enum logic [1:0] {
        ST_ACQ   = 2'd0,
        ST_CHECK = 2'd1,
        ST_SYNC  = 2'd2
    } sync_st_t;

    // Register length n for each sequence select code.
    function automatic logic [4:0] seq_len(input logic [2:0] sel);
        case (sel)
            3'd0:    return 5'd7;
            3'd1:    return 5'd9;
            3'd2:    return 5'd11;
            3'd3:    return 5'd15;
            3'd4:    return 5'd20;
            3'd5:    return 5'd23;
            default: return 5'd31;
        endcase
    endfunction

    // Inner tap m for each sequence select code.
    function automatic logic [4:0] seq_tap(input logic [2:0] sel);
        case (sel)
            3'd0:    return 5'd6;
            3'd1:    return 5'd5;
            3'd2:    return 5'd9;
            3'd3:    return 5'd14;
            3'd4:    return 5'd3;
            3'd5:    return 5'd18;
            default: return 5'd28;
        endcase
    endfunction

    // Window length 10^(k+1) for exponent k, with k clamped to 2..8.
    function automatic logic [31:0] win_len(input logic [3:0] k);
        case (k)
            4'd0, 4'd1, 4'd2: return 32'd1000;
            4'd3:             return 32'd10000;
            4'd4:             return 32'd100000;
            4'd5:             return 32'd1000000;
            4'd6:             return 32'd10000000;
            4'd7:             return 32'd100000000;
            default:          return 32'd1000000000;
        endcase
    endfunction

endpackage

// File: rtl/prbs_chk_ref.sv
// Reference sequence register. In seed mode it shifts in received bits.
// Otherwise it shifts in its own predicted bit.
// Assumes len is in 3..31 and tap is less than len.
module prbs_chk_ref
    import prbs_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       seed_mode,
    input  logic [4:0] len,
    input  logic [4:0] tap,
    output logic       mismatch
);

    logic [REF_W-1:0] sr_q;
    logic             pred;

    // Predict the next bit from the two taps of the recurrence.
    always_comb begin
        pred     = sr_q[5'(len - 5'd1)] ^ sr_q[5'(tap - 5'd1)];
        mismatch = bit_in ^ pred;
    end

    // Advance the register on each enabled bit, fed by the input or by the loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (bit_en) begin
            sr_q <= {sr_q[REF_W-2:0], seed_mode ? bit_in : pred};
        end
    end

endmodule

// File: rtl/prbs_chk_sync.sv
// Lock state machine: acquire for n bits, confirm over the gain window,
// then watch the loss windows.
// Assumes the window lengths stay constant while a window is open.
module prbs_chk_sync
    import prbs_chk_pkg::*;
#(
    parameter int ERR_LIMIT = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  logic        mismatch,
    input  logic [4:0]  len,
    input  logic [31:0] gain_len,
    input  logic [31:0] loss_len,
    output logic        seed_mode,
    output logic        in_sync,
    output logic        gain_evt
);

    localparam int EW = $clog2(ERR_LIMIT + 1);

    sync_st_t    st_q;
    logic [4:0]  acq_q;
    logic [31:0] win_q;
    logic [EW-1:0] err_q;
    logic [31:0] cur_len;
    logic        acq_done;
    logic        win_end;
    logic        over;

    // Decode the window end and the error limit for the current phase.
    always_comb begin
        cur_len   = (st_q == ST_CHECK) ? gain_len : loss_len;
        acq_done  = (acq_q == 5'(len - 5'd1));
        win_end   = (win_q == cur_len - 32'd1);
        over      = mismatch && (int'(err_q) == ERR_LIMIT);
        seed_mode = (st_q == ST_ACQ);
        in_sync   = (st_q == ST_SYNC);
        gain_evt  = bit_en && (st_q == ST_CHECK) && !over && win_end;
    end

    // Step the phase, the window counter and the window error tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_ACQ;
            acq_q <= '0;
            win_q <= '0;
            err_q <= '0;
        end else if (bit_en) begin
            case (st_q)
                ST_ACQ: begin
                    if (acq_done) begin
                        st_q  <= ST_CHECK;
                        acq_q <= '0;
                        win_q <= '0;
                        err_q <= '0;
                    end else begin
                        acq_q <= acq_q + 5'd1;
                    end
                end
                default: begin
                    if (over) begin
                        st_q  <= ST_ACQ;
                        acq_q <= '0;
                        win_q <= '0;
                        err_q <= '0;
                    end else if (win_end) begin
                        st_q  <= ST_SYNC;
                        win_q <= '0;
                        err_q <= '0;
                    end else begin
                        win_q <= win_q + 32'd1;
                        err_q <= err_q + EW'(mismatch);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/prbs_chk_mask.sv
// Position counter and mask decode. Position 0 is the first bit after lock.
// Assumes POS_W is at least 6.
module prbs_chk_mask #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic             blk_en,
    input  logic [POS_W-6:0] blk_idx,
    input  logic             bit_en,
    input  logic [4:0]       bit_off,
    output logic             masked
);

    logic [POS_W-1:0] pos_q;

    // Count the position of each locked bit, restarting at lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clr) begin
            pos_q <= '0;
        end else if (adv) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Combine the block mask and the one-in-32 mask.
    always_comb begin
        masked = (blk_en && (pos_q[POS_W-1:5] == blk_idx)) ||
                 (bit_en && (pos_q[4:0] == bit_off));
    end

endmodule

// File: rtl/prbs_chk_satcnt.sv
// Saturating up-counter with a synchronous clear that takes priority.
// Assumes W is at least 1.
module prbs_chk_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    // Increment until all ones, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (inc && !(&q)) begin
            q <= q + 1'b1;
        end
    end

endmodule

// File: rtl/prbs_chk.sv
// Top of the self-synchronising PRBS checker: reference register,
// lock state machine, mask decode and two saturating counters.
// Assumes rx_bit is meaningful only when rx_en is high.
module prbs_chk
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int POS_W     = 16,
    parameter int ERR_LIMIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_en,
    input  logic [2:0]       poly_sel,
    input  logic [3:0]       gain_sel,
    input  logic [3:0]       loss_sel,
    input  logic             blk_mask_en,
    input  logic [POS_W-6:0] blk_mask_idx,
    input  logic             bit_mask_en,
    input  logic [4:0]       bit_mask_off,
    output logic             in_sync,
    output logic [CNT_W-1:0] err_cnt,
    output logic [CNT_W-1:0] bit_cnt
);

    localparam int N_CNT = 2;

    logic [4:0]       len;
    logic [4:0]       tap;
    logic [31:0]      gain_len;
    logic [31:0]      loss_len;
    logic             mismatch;
    logic             seed_mode;
    logic             gain_evt;
    logic             masked;
    logic             take;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_q [N_CNT];

    // Look up the recurrence and the window lengths from the selects.
    always_comb begin
        len      = seq_len(poly_sel);
        tap      = seq_tap(poly_sel);
        gain_len = win_len(gain_sel);
        loss_len = win_len(loss_sel);
        take     = rx_en && in_sync && !masked;
        cnt_inc  = {take && mismatch, take};
    end

    prbs_chk_ref ref_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (rx_en),
        .bit_in    (rx_bit),
        .seed_mode (seed_mode),
        .len       (len),
        .tap       (tap),
        .mismatch  (mismatch)
    );

    prbs_chk_sync #(.ERR_LIMIT(ERR_LIMIT)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (rx_en),
        .mismatch  (mismatch),
        .len       (len),
        .gain_len  (gain_len),
        .loss_len  (loss_len),
        .seed_mode (seed_mode),
        .in_sync   (in_sync),
        .gain_evt  (gain_evt)
    );

    prbs_chk_mask #(.POS_W(POS_W)) mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (gain_evt),
        .adv     (rx_en && in_sync),
        .blk_en  (blk_mask_en),
        .blk_idx (blk_mask_idx),
        .bit_en  (bit_mask_en),
        .bit_off (bit_mask_off),
        .masked  (masked)
    );

    // Index 0 counts compared bits; index 1 counts errors.
    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
        prbs_chk_satcnt #(.W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (gain_evt),
            .inc   (cnt_inc[gi]),
            .q     (cnt_q[gi])
        );
    end

    assign bit_cnt = cnt_q[0];
    assign err_cnt = cnt_q[1];

endmodule

// File: rtl/prbs_chk_sva.sv
// Assertion checker for prbs_chk, attached through bind.
// Checks the counter rules and the lock edge on every clock.
module prbs_chk_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             in_sync,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] bit_cnt
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!in_sync && err_cnt == '0 && bit_cnt == '0));

    p_errs_within_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= bit_cnt);

    p_frozen_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sync && !$past(in_sync)) |-> ($stable(bit_cnt) && $stable(err_cnt)));

    p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(in_sync) |-> (bit_cnt == $past(bit_cnt) || bit_cnt == $past(bit_cnt) + 1'b1));

    p_idle_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rx_en) && !$rose(in_sync)) |-> ($stable(bit_cnt) && $stable(err_cnt)));

    p_lock_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(rx_en));

    p_hold_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&bit_cnt) && !$rose(in_sync)) |-> (&bit_cnt));

endmodule

bind prbs_chk prbs_chk_sva #(.CNT_W(CNT_W)) sva_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .in_sync (in_sync),
    .err_cnt (err_cnt),
    .bit_cnt (bit_cnt)
);

// File: tb/prbs_chk_tb_top.sv
// Directed bench for prbs_chk: one task for each scenario.
module prbs_chk_tb_top;

    localparam int CNT_W = 10;
    localparam int POS_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_bit = 1'b0;
    logic             rx_en = 1'b0;
    logic [2:0]       poly_sel = 3'd0;
    logic [3:0]       gain_sel = 4'd2;
    logic [3:0]       loss_sel = 4'd2;
    logic             blk_mask_en = 1'b0;
    logic [POS_W-6:0] blk_mask_idx = '0;
    logic             bit_mask_en = 1'b0;
    logic [4:0]       bit_mask_off = 5'd0;
    logic             in_sync;
    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] bit_cnt;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    // Bench-side sequence generator.
    logic [30:0] g;
    int          g_len = 7;
    int          g_tap = 6;

    always #10 clk = ~clk;

    prbs_chk #(.CNT_W(CNT_W), .POS_W(POS_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_bit       (rx_bit),
        .rx_en        (rx_en),
        .poly_sel     (poly_sel),
        .gain_sel     (gain_sel),
        .loss_sel     (loss_sel),
        .blk_mask_en  (blk_mask_en),
        .blk_mask_idx (blk_mask_idx),
        .bit_mask_en  (bit_mask_en),
        .bit_mask_off (bit_mask_off),
        .in_sync      (in_sync),
        .err_cnt      (err_cnt),
        .bit_cnt      (bit_cnt)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    task automatic gen_start(input int len, input int tap);
        g_len = len;
        g_tap = tap;
        g = '1;
    endtask

    // Present one enabled bit, optionally inverted, and wait past the edge.
    task automatic send(input logic flip);
        logic b;
        b = g[g_len-1] ^ g[g_tap-1];
        g = {g[29:0], b};
        rx_bit = b ^ flip;
        rx_en = 1'b1;
        @(posedge clk);
        #2;
        rx_en = 1'b0;
    endtask

    task automatic send_n(input int n);
        for (int i = 0; i < n; i++) send(1'b0);
    endtask

    // A cycle with rx_en low and an arbitrary data bit.
    task automatic idle();
        rx_bit = 1'($urandom);
        rx_en = 1'b0;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        chk("R1 in_sync", in_sync, 0);
        chk("R1 err_cnt", err_cnt, 0);
        chk("R1 bit_cnt", bit_cnt, 0);
    endtask

    // PRBS7 lock after 7 + 1000 enabled bits, with idle cycles mixed in.
    task automatic t_gain_prbs7();
        gen_start(7, 6);
        for (int i = 0; i < 1006; i++) begin
            send(1'b0);
            if (i % 3 == 0) idle();
        end
        chk("R3 R7 no lock at bit 1006", in_sync, 0);
        send(1'b0);
        chk("R2 R3 lock at bit 1007", in_sync, 1);
        chk("R8 bit_cnt cleared at lock", bit_cnt, 0);
    endtask

    // Ten errors in one loss window keep lock; the eleventh drops it.
    task automatic t_hold_and_loss();
        send_n(200);
        for (int i = 0; i < 10; i++) begin
            send(1'b1);
            send_n(9);
        end
        send_n(700);
        chk("R5 ten errors keep lock", in_sync, 1);
        chk("R8 err_cnt after window", err_cnt, 10);
        chk("R8 bit_cnt after window", bit_cnt, 1000);
        for (int i = 0; i < 10; i++) send(1'b1);
        chk("R5 lock held at 10 errors", in_sync, 1);
        send(1'b1);
        chk("R5 lock lost at 11th error", in_sync, 0);
        chk("R8 err_cnt includes loss bit", err_cnt, 21);
        send_n(5);
        chk("R8 bit_cnt frozen when unlocked", bit_cnt, 1011);
    endtask

    // Re-seed from the stream and lock again.
    task automatic t_resync();
        send_n(1001);
        chk("R6 no lock before window end", in_sync, 0);
        send(1'b0);
        chk("R6 relock after reseed", in_sync, 1);
        chk("R6 err_cnt cleared", err_cnt, 0);
    endtask

    // Block 2 plus offset 1 masked over 128 positions; errors at 0, 1, 70, 100.
    task automatic t_mask();
        blk_mask_en  = 1'b1;
        blk_mask_idx = 11'd2;
        bit_mask_en  = 1'b1;
        bit_mask_off = 5'd1;
        for (int i = 0; i < 128; i++) begin
            send((i == 0) || (i == 1) || (i == 70) || (i == 100));
        end
        chk("R9 R10 masked err_cnt", err_cnt, 2);
        chk("R9 R10 masked bit_cnt", bit_cnt, 93);
        blk_mask_en = 1'b0;
        bit_mask_en = 1'b0;
    endtask

    task automatic t_saturate();
        send_n(1000);
        chk("R11 bit_cnt saturates", bit_cnt, 1023);
        chk("R11 err_cnt held", err_cnt, 2);
    endtask

    // A PRBS9 stream checked against the PRBS7 recurrence never locks.
    task automatic t_wrong_poly();
        gen_start(9, 5);
        send_n(3000);
        chk("R4 no lock on wrong sequence", in_sync, 0);
    endtask

    // PRBS31 with gain k=3 and loss k=2.
    task automatic t_gain_sel();
        do_reset();
        poly_sel = 3'd6;
        gain_sel = 4'd3;
        loss_sel = 4'd2;
        gen_start(31, 28);
        send_n(31 + 9999);
        chk("R12 no lock before 10000-bit window", in_sync, 0);
        send(1'b0);
        chk("R2 R12 PRBS31 lock", in_sync, 1);
        send_n(990);
        for (int i = 0; i < 10; i++) send(1'b1);
        for (int i = 0; i < 5; i++) send(1'b1);
        chk("R12 loss window is 1000 bits", in_sync, 1);
        chk("R12 err_cnt", err_cnt, 15);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_gain_prbs7();
        t_hold_and_loss();
        t_resync();
        t_mask();
        t_saturate();
        t_wrong_poly();
        t_gain_sel();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule